// File: doc/BRIEF.md
# Interleaved Operand SRAM Loader

This block owns the working memory of a big-number arithmetic engine. The memory is 1536 dwords (6144 bytes) and holds three operands of up to 512 dwords each: an exponent, a modulus and a data value. The operands are not stored in separate regions. They are interleaved in groups of four dwords, and each group of twelve physical dwords carries four exponent dwords, then four modulus dwords, then four data dwords. A producer writes operands one logical 32-bit word at a time, least significant word at index 0. The block computes the physical location of each word. The arithmetic engine reads the physical image through a separate read port.

After an operation the result sits in the data region. The unload side walks that region from its most significant byte downward. It skips zero bytes until it finds the first nonzero byte, and from then on it emits every byte, zeros included, over a valid/ready byte stream. When the walk ends, the block publishes the number of bytes it emitted.

A clear operation zeroes the whole memory and raises a done flag when it finishes. Loads and unloads are refused while a clear runs.

Top module: `operand_sram_loader`

## Requirements
- R1: A load with select 0 (exponent) at logical index i writes physical dword 12*(i/4) + (i%4).
- R2: A load with select 1 (modulus) at logical index i writes physical dword 12*(i/4) + (i%4) + 4.
- R3: A load with select 2 (data) at logical index i writes physical dword 12*(i/4) + (i%4) + 8. Bits [8b+7:8b] of that word are logical data byte 4i+b, and logical byte 0 is the least significant byte of the number.
- R4: An unload scans logical data bytes from 2047 down to 0 and skips zero bytes until the first nonzero byte. After that it emits every byte in scan order, including zeros.
- R5: When the walk ends, ul_len_valid rises and ul_len equals 2048 minus the number of skipped leading zero bytes.
- R6: If every data byte is zero, the unload emits no byte and reports a length of 0.
- R7: While ul_valid is high and ul_ready is low, ul_valid stays high and ul_byte and ul_last stay unchanged on the next cycle.
- R8: ul_last is high exactly on the final emitted byte, which is logical byte 0, and only together with ul_valid.
- R9: A clear writes zero to all 1536 dwords. clr_busy is high during the clear, and clr_done rises 1536 cycles after the start is taken and stays high until the next clear starts.
- R10: While a clear runs, load requests and unload starts are ignored.
- R11: A load with select 3 is ignored, and a load issued while an unload runs is ignored.
- R12: The engine read port returns the physical dword at eng_addr one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_start | input | 1 | Start zeroing the whole memory |
| clr_busy | output | 1 | Clear in progress |
| clr_done | output | 1 | Last clear finished |
| ld_valid | input | 1 | Load request this cycle |
| ld_sel | input | 2 | Operand select: 0 exponent, 1 modulus, 2 data, 3 none |
| ld_index | input | 9 | Logical word index, 0 = least significant |
| ld_data | input | 32 | Word to store |
| ul_start | input | 1 | Start a result unload |
| ul_busy | output | 1 | Unload in progress |
| ul_byte | output | 8 | Streamed result byte, most significant first |
| ul_valid | output | 1 | ul_byte is valid |
| ul_ready | input | 1 | Consumer accepts ul_byte |
| ul_last | output | 1 | Final byte of the stream |
| ul_len | output | 12 | Result length in bytes |
| ul_len_valid | output | 1 | ul_len holds the length of the last unload |
| eng_addr | input | 11 | Physical dword address for the engine |
| eng_data | output | 32 | Physical dword read, one cycle latency |

## Verification
Loads with all three selects go to first-group, middle-group and last-group indices. The engine port then shows each exponent, modulus and data word at its own stride offset, which separates offset errors from group-stride errors. The unload is tried with four data patterns: a full-width value whose top byte is nonzero, which shows no byte is dropped and the length saturates; a short value with zeros both above and inside it, which separates leading-zero skipping from interior-zero loss; a single low byte, which checks last and length 1; and an all-zero image. A pseudo-random ready pattern stresses the hold-under-stall rule.

// File: rtl/opsram_pkg.sv
// Shared types for the interleaved operand SRAM loader.
// Assumes the operand select encoding is fixed at two bits.
package opsram_pkg;

    typedef enum logic [1:0] {
        OP_EXP  = 2'd0,
        OP_MOD  = 2'd1,
        OP_DATA = 2'd2,
        OP_NONE = 2'd3
    } op_sel_e;

    typedef enum logic [1:0] {
        U_IDLE  = 2'd0,
        U_FETCH = 2'd1,
        U_SCAN  = 2'd2,
        U_EMIT  = 2'd3
    } ustate_e;

    // dwords per operand group and physical dwords per group
    localparam int GROUP_DW  = 4;
    localparam int STRIDE_DW = 12;

endpackage

// File: rtl/opsram_addr_map.sv
// Maps (operand select, logical dword index) to a physical dword address.
// Assumes select is one of exponent, modulus or data; groups of four,
// stride twelve, operand offset four dwords per select step.
module opsram_addr_map #(
    parameter int IW = 9,
    parameter int AW = 11
) (
    input  logic [1:0]    sel,
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] addr
);
    localparam int GW = IW - 2;

    logic [GW-1:0] grp;
    logic [1:0]    lane;

    // split index and form 12*g + k + 4*sel
    always_comb begin
        grp  = idx[IW-1:2];
        lane = idx[1:0];
        addr = (AW'(grp) << 3) + (AW'(grp) << 2) + AW'(lane) + (AW'(sel) << 2);
    end
endmodule

// File: rtl/opsram_store.sv
// Operand memory: one write port and two registered read ports.
// Assumes addresses stay below DEPTH; contents are not reset.
module opsram_store #(
    parameter int DEPTH = 1536,
    parameter int AW    = 11,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem [DEPTH];

    // write port
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // registered read ports
    always_ff @(posedge clk) begin
        rdata_a <= mem[raddr_a];
        rdata_b <= mem[raddr_b];
    end
endmodule

// File: rtl/opsram_clear.sv
// Sequencer that walks every dword once to zero it.
// Assumes start is only asserted when the caller allows it.
module opsram_clear #(
    parameter int DEPTH = 1536,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] waddr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // address counter and busy/done flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            waddr <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            done  <= 1'b0;
            waddr <= '0;
        end else if (busy) begin
            if (waddr == LAST) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                waddr <= waddr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/opsram_unload.sv
// Walks the data operand from its top byte down, strips leading zero
// bytes, streams the rest over valid/ready and reports the length.
// Assumes the memory is not written while busy and that rdata is the
// registered read of the word index presented on rd_idx.
module opsram_unload
    import opsram_pkg::*;
#(
    parameter int OP_WORDS = 512,
    parameter int DW       = 32,
    localparam int IW      = $clog2(OP_WORDS),
    localparam int BPW     = DW / 8,
    localparam int BW      = $clog2(BPW),
    localparam int BYTES   = OP_WORDS * BPW,
    localparam int LW      = $clog2(BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic [IW-1:0] rd_idx,
    input  logic [DW-1:0] rdata,
    output logic [7:0]    out_byte,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_last,
    output logic [LW-1:0] len,
    output logic          len_valid
);
    ustate_e       state;
    logic [IW-1:0] word;
    logic [BW-1:0] lane;
    logic [LW-1:0] skipped;
    logic          started;

    logic [7:0]    cur_byte;
    logic          skip_now;
    logic          step;
    logic          at_end;
    logic [LW-1:0] skipped_nxt;

    // current byte and walk-advance decisions
    always_comb begin
        cur_byte    = rdata[8*lane +: 8];
        skip_now    = (state == U_SCAN) && !started && (cur_byte == 8'd0);
        step        = skip_now || ((state == U_EMIT) && out_ready);
        at_end      = (word == '0) && (lane == '0);
        skipped_nxt = skipped + LW'(skip_now);
        busy        = (state != U_IDLE);
        rd_idx      = word;
    end

    // walk state, stream register and length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= U_IDLE;
            word      <= '0;
            lane      <= '0;
            skipped   <= '0;
            started   <= 1'b0;
            out_byte  <= '0;
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            len       <= '0;
            len_valid <= 1'b0;
        end else begin
            case (state)
                U_IDLE: begin
                    if (start) begin
                        word      <= IW'(OP_WORDS - 1);
                        lane      <= BW'(BPW - 1);
                        skipped   <= '0;
                        started   <= 1'b0;
                        len_valid <= 1'b0;
                        state     <= U_FETCH;
                    end
                end
                U_FETCH: state <= U_SCAN;
                U_SCAN: begin
                    skipped <= skipped_nxt;
                    if (!skip_now) begin
                        out_byte  <= cur_byte;
                        out_valid <= 1'b1;
                        out_last  <= at_end;
                        started   <= 1'b1;
                        state     <= U_EMIT;
                    end
                end
                U_EMIT: begin
                    if (out_ready) begin
                        out_valid <= 1'b0;
                        out_last  <= 1'b0;
                    end
                end
                default: state <= U_IDLE;
            endcase

            if (step) begin
                if (lane != '0) begin
                    lane  <= lane - 1'b1;
                    state <= U_SCAN;
                end else if (word != '0) begin
                    word  <= word - 1'b1;
                    lane  <= BW'(BPW - 1);
                    state <= U_FETCH;
                end else begin
                    len       <= LW'(BYTES) - skipped_nxt;
                    len_valid <= 1'b1;
                    state     <= U_IDLE;
                end
            end
        end
    end
endmodule

// File: rtl/operand_sram_loader.sv
// Top: interleaved operand memory with word loader, clear sequencer,
// stripped result unloader and an engine-side physical read port.
// Assumes DATA_W is a multiple of 8 and OP_WORDS a multiple of four.
// A clear has priority; loads and unload starts are refused while busy.
module operand_sram_loader
    import opsram_pkg::*;
#(
    parameter int OP_WORDS = 512,
    parameter int DATA_W   = 32,
    localparam int DEPTH   = 3 * OP_WORDS,
    localparam int AW      = $clog2(DEPTH),
    localparam int IW      = $clog2(OP_WORDS),
    localparam int BYTES   = OP_WORDS * (DATA_W / 8),
    localparam int LW      = $clog2(BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_start,
    output logic              clr_busy,
    output logic              clr_done,
    input  logic              ld_valid,
    input  logic [1:0]        ld_sel,
    input  logic [IW-1:0]     ld_index,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ul_start,
    output logic              ul_busy,
    output logic [7:0]        ul_byte,
    output logic              ul_valid,
    input  logic              ul_ready,
    output logic              ul_last,
    output logic [LW-1:0]     ul_len,
    output logic              ul_len_valid,
    input  logic [AW-1:0]     eng_addr,
    output logic [DATA_W-1:0] eng_data
);
    logic              ld_take, clr_take, ul_take;
    logic [AW-1:0]     ld_addr, clr_addr, ul_addr, wr_addr;
    logic [IW-1:0]     ul_idx;
    logic [DATA_W-1:0] ul_rdata, wr_data;
    logic              wr_en;

    // request acceptance and write-port arbitration
    always_comb begin
        ld_take  = ld_valid && (ld_sel != OP_NONE) && !clr_busy && !ul_busy;
        clr_take = clr_start && !clr_busy && !ul_busy;
        ul_take  = ul_start && !clr_busy && !ul_busy;
        wr_en    = clr_busy || ld_take;
        wr_addr  = clr_busy ? clr_addr : ld_addr;
        wr_data  = clr_busy ? '0 : ld_data;
    end

    opsram_addr_map #(.IW(IW), .AW(AW)) u_map_ld (
        .sel  (ld_sel),
        .idx  (ld_index),
        .addr (ld_addr)
    );

    opsram_addr_map #(.IW(IW), .AW(AW)) u_map_ul (
        .sel  (OP_DATA),
        .idx  (ul_idx),
        .addr (ul_addr)
    );

    opsram_store #(.DEPTH(DEPTH), .AW(AW), .DW(DATA_W)) u_store (
        .clk     (clk),
        .we      (wr_en),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .raddr_a (ul_addr),
        .rdata_a (ul_rdata),
        .raddr_b (eng_addr),
        .rdata_b (eng_data)
    );

    opsram_clear #(.DEPTH(DEPTH), .AW(AW)) u_clear (
        .clk   (clk),
        .rst_n (rst_n),
        .start (clr_take),
        .busy  (clr_busy),
        .done  (clr_done),
        .waddr (clr_addr)
    );

    opsram_unload #(.OP_WORDS(OP_WORDS), .DW(DATA_W)) u_unload (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ul_take),
        .busy      (ul_busy),
        .rd_idx    (ul_idx),
        .rdata     (ul_rdata),
        .out_byte  (ul_byte),
        .out_valid (ul_valid),
        .out_ready (ul_ready),
        .out_last  (ul_last),
        .len       (ul_len),
        .len_valid (ul_len_valid)
    );
endmodule

// File: rtl/opsram_loader_checker.sv
// Protocol checker for the operand SRAM loader, bound to the top.
module opsram_loader_checker #(
    parameter int OP_WORDS = 512,
    localparam int BYTES   = OP_WORDS * 4,
    localparam int LW      = $clog2(BYTES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr_busy,
    input logic          clr_done,
    input logic          ul_busy,
    input logic          ul_valid,
    input logic          ul_ready,
    input logic [7:0]    ul_byte,
    input logic          ul_last,
    input logic [LW-1:0] ul_len,
    input logic          ul_len_valid
);
    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ul_valid && !ul_ready) |=> (ul_valid && $stable(ul_byte) && $stable(ul_last)));

    assert_last_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ul_last |-> ul_valid);

    assert_len_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ul_len_valid |-> (int'(ul_len) <= BYTES));

    assert_clear_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_busy |-> (!ul_busy && !ul_valid));

    assert_clear_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clr_busy) |-> clr_done);

    assert_no_len_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ul_busy) |=> !ul_len_valid);
endmodule

bind operand_sram_loader opsram_loader_checker #(.OP_WORDS(OP_WORDS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_busy     (clr_busy),
    .clr_done     (clr_done),
    .ul_busy      (ul_busy),
    .ul_valid     (ul_valid),
    .ul_ready     (ul_ready),
    .ul_byte      (ul_byte),
    .ul_last      (ul_last),
    .ul_len       (ul_len),
    .ul_len_valid (ul_len_valid)
);

// File: tb/operand_sram_loader_tb.sv
// Directed bench for the operand SRAM loader: one task per scenario.
module operand_sram_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_start = 1'b0;
    logic        clr_busy, clr_done;
    logic        ld_valid = 1'b0;
    logic [1:0]  ld_sel = 2'd0;
    logic [8:0]  ld_index = '0;
    logic [31:0] ld_data = '0;
    logic        ul_start = 1'b0;
    logic        ul_busy;
    logic [7:0]  ul_byte;
    logic        ul_valid;
    logic        ul_ready = 1'b0;
    logic        ul_last;
    logic [11:0] ul_len;
    logic        ul_len_valid;
    logic [10:0] eng_addr = '0;
    logic [31:0] eng_data;

    int checks = 0;
    int errs   = 0;
    logic [7:0] model [2048];
    logic [7:0] expq  [2048];
    logic [15:0] lf = 16'hACE1;

    operand_sram_loader u_dut (
        .clk(clk), .rst_n(rst_n),
        .clr_start(clr_start), .clr_busy(clr_busy), .clr_done(clr_done),
        .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_index(ld_index), .ld_data(ld_data),
        .ul_start(ul_start), .ul_busy(ul_busy), .ul_byte(ul_byte), .ul_valid(ul_valid),
        .ul_ready(ul_ready), .ul_last(ul_last), .ul_len(ul_len), .ul_len_valid(ul_len_valid),
        .eng_addr(eng_addr), .eng_data(eng_data)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic model_zero();
        for (int i = 0; i < 2048; i++) model[i] = 8'h00;
    endtask

    task automatic load(input logic [1:0] sel, input int idx, input logic [31:0] d);
        @(negedge clk);
        ld_valid = 1'b1; ld_sel = sel; ld_index = 9'(idx); ld_data = d;
        @(negedge clk);
        ld_valid = 1'b0;
        if (sel == 2'd2)
            for (int b = 0; b < 4; b++) model[4*idx + b] = d[8*b +: 8];
    endtask

    task automatic eng_read(input int addr, output logic [31:0] d);
        @(negedge clk);
        eng_addr = 11'(addr);
        @(negedge clk);
        d = eng_data;
    endtask

    // R9: clear timing and zero contents
    task automatic t_clear(input bit full_check);
        int n;
        logic [31:0] d;
        @(negedge clk);
        clr_start = 1'b1;
        @(negedge clk);
        clr_start = 1'b0;
        n = 1;
        if (full_check) begin
            chk(clr_busy === 1'b1 && clr_done === 1'b0, "R9 busy after start", {clr_busy, clr_done}, 32'h2);
            // R10: unload start and load ignored during clear
            ul_start = 1'b1; ld_valid = 1'b1; ld_sel = 2'd2; ld_index = 9'd511; ld_data = 32'hFFFF_FFFF;
            @(negedge clk);
            n++;
            ul_start = 1'b0; ld_valid = 1'b0;
            chk(ul_busy === 1'b0, "R10 unload start ignored in clear", ul_busy, 0);
        end
        while (!clr_done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        model_zero();
        if (full_check) begin
            chk(n == 1537, "R9 done latency", n, 1537);
            eng_read(0, d);    chk(d === 0, "R9 dword 0 cleared", d, 0);
            eng_read(1535, d); chk(d === 0, "R10 load in clear ignored (1535)", d, 0);
            eng_read(767, d);  chk(d === 0, "R9 dword 767 cleared", d, 0);
        end
    endtask

    // R4 R5 R6 R7 R8: run one unload against the model
    task automatic run_unload(input bit stall, input bit inject, input string tag);
        int exp_n = 0, got_n = 0, bad = 0, badlast = 0, badhold = 0, it = 0;
        bit seen = 1'b0;
        bit prev_stall = 1'b0;
        logic [7:0] prev_byte = '0;
        bit nr;
        for (int i = 2047; i >= 0; i--) begin
            if (model[i] != 8'h00) seen = 1'b1;
            if (seen) begin expq[exp_n] = model[i]; exp_n++; end
        end
        @(negedge clk);
        ul_start = 1'b1;
        @(negedge clk);
        ul_start = 1'b0;
        while (!ul_len_valid && it < 30000) begin
            if (inject && it == 2) begin
                ld_valid = 1'b1; ld_sel = 2'd2; ld_index = 9'd3; ld_data = 32'h5A5A_5A5A;
            end else begin
                ld_valid = 1'b0;
            end
            if (prev_stall && !(ul_valid && ul_byte == prev_byte)) badhold++;
            if (stall) begin
                nr = lf[0];
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            end else begin
                nr = 1'b1;
            end
            ul_ready = nr;
            if (ul_valid && nr) begin
                if (got_n >= exp_n || ul_byte !== expq[got_n]) bad++;
                if (ul_last !== (got_n == exp_n - 1)) badlast++;
                got_n++;
            end
            prev_stall = ul_valid && !nr;
            prev_byte  = ul_byte;
            @(negedge clk);
            it++;
        end
        ld_valid = 1'b0;
        ul_ready = 1'b0;
        chk(bad == 0, {"R4 stream bytes ", tag}, bad, 0);
        chk(got_n == exp_n, {"R4 stream count ", tag}, got_n, exp_n);
        chk(badlast == 0, {"R8 last flag ", tag}, badlast, 0);
        chk(ul_len_valid === 1'b1 && ul_len == 12'(exp_n), {"R5 length ", tag}, ul_len, exp_n);
        if (stall) chk(badhold == 0, {"R7 hold under stall ", tag}, badhold, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(clr_busy === 0 && clr_done === 0, "R9 reset clear flags", {clr_busy, clr_done}, 0);
        chk(ul_busy === 0 && ul_valid === 0 && ul_len_valid === 0 && ul_last === 0,
            "R5 reset unload idle", {ul_busy, ul_valid, ul_len_valid, ul_last}, 0);
    endtask

    // R1 R2 R3 R12: placement of each operand word
    task automatic t_mapping();
        logic [31:0] d;
        load(2'd0, 5,   32'hE0E0_0005);
        load(2'd1, 5,   32'hB0B0_0005);
        load(2'd2, 5,   32'hD0D0_0005);
        load(2'd0, 511, 32'hE0E0_01FF);
        load(2'd1, 511, 32'hB0B0_01FF);
        load(2'd2, 511, 32'hA500_0001);
        load(2'd0, 0,   32'hE0E0_0000);
        eng_read(13, d);   chk(d === 32'hE0E0_0005, "R1 exp idx5 at 13", d, 32'hE0E0_0005);
        eng_read(1527, d); chk(d === 32'hE0E0_01FF, "R1 exp idx511 at 1527", d, 32'hE0E0_01FF);
        eng_read(0, d);    chk(d === 32'hE0E0_0000, "R1 R12 exp idx0 at 0", d, 32'hE0E0_0000);
        eng_read(17, d);   chk(d === 32'hB0B0_0005, "R2 mod idx5 at 17", d, 32'hB0B0_0005);
        eng_read(1531, d); chk(d === 32'hB0B0_01FF, "R2 mod idx511 at 1531", d, 32'hB0B0_01FF);
        eng_read(21, d);   chk(d === 32'hD0D0_0005, "R3 data idx5 at 21", d, 32'hD0D0_0005);
        eng_read(1535, d); chk(d === 32'hA500_0001, "R3 data idx511 at 1535", d, 32'hA500_0001);
    endtask

    // R4: full-width value under back-pressure
    task automatic t_full();
        run_unload(1'b1, 1'b0, "full");
        chk(ul_len == 12'd2048, "R5 full length 2048", ul_len, 2048);
    endtask

    // R3 R4: leading and interior zeros
    task automatic t_interior();
        t_clear(1'b0);
        load(2'd2, 1, 32'h0000_1200);
        load(2'd2, 0, 32'h0034_0056);
        run_unload(1'b0, 1'b0, "interior");
        chk(ul_len == 12'd6, "R3 R5 interior length 6", ul_len, 6);
    endtask

    // R8: single low byte
    task automatic t_single();
        t_clear(1'b0);
        load(2'd2, 0, 32'h0000_0001);
        run_unload(1'b1, 1'b0, "single");
    endtask

    // R6 R11: all-zero image, ignored loads
    task automatic t_zero_and_ignored();
        logic [31:0] d;
        t_clear(1'b0);
        load(2'd3, 0, 32'h7777_7777);
        eng_read(12, d); chk(d === 0, "R11 select 3 ignored (12)", d, 0);
        eng_read(8, d);  chk(d === 0, "R11 select 3 ignored (8)", d, 0);
        run_unload(1'b0, 1'b1, "zero");
        chk(ul_len == 12'd0, "R6 zero length", ul_len, 0);
        eng_read(11, d); chk(d === 0, "R11 load during unload ignored", d, 0);
    endtask

    initial begin
        model_zero();
        t_reset();
        t_clear(1'b1);
        t_mapping();
        t_full();
        t_interior();
        t_single();
        t_zero_and_ignored();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        errs++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule